// File: doc/BRIEF.md
# PCI Inbound DMA Target Window Decoder

This block sits on the inbound side of a host bridge. It compares each PCI memory address presented to it with four programmable target windows. When a window claims the address, it reports which window won and produces a 34-bit physical memory address by direct mapping. If the winning window is marked for scatter-gather, it raises a request flag so that a separate page-table unit can take over. Each window has three registers: a base/control word, a size mask and a translated base. The last window also has a fourth register that holds the upper dword matched on 64-bit (dual-address) cycles.

Window size is set by a 12-bit mask over address bits 31:20. Each mask bit that is set widens the window by one address bit, from 1MB up to 4GB. Bits under a set mask bit pass straight from the PCI address into the physical address. Bits under a clear mask bit are compared against the base and are replaced by the translated base. Window 0 can instead follow an external memory chip-select decode, so that a legacy region is claimed without any address compare. A lookup is presented with a one-cycle strobe, and the result appears on the registered outputs in the following cycle. Software programs the windows through a flat register port.

Top module: `dma_window_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, every window register and the translated bases are cleared. `res_valid`, `res_hit`, `res_claim` and `mask_err` are then 0, and every register reads back as 0.
- R2: `cfg_addr` selects window `cfg_addr[3:2]` and register `cfg_addr[1:0]`: 0 base/control, 1 mask, 2 translated base, 3 upper dword for dual-address cycles. Base/control holds enable in bit 0, scatter-gather in bit 1, dual-address enable in bit 2, chip-select follow in bit 3 and the base in bits 31:20. The mask register holds the mask in bits 31:20. The translated base holds physical bits 33:20 in bits 13:0. Writes take effect at the clock edge, and reads are combinational. The dual-address enable and the upper-dword register exist only on window 3, and chip-select follow exists only on window 0. Elsewhere these bits are dropped and read back as 0.
- R3: On a single-address cycle, an enabled window with a valid mask hits when PCI address bits 31:20 equal the base in every position where the mask bit is 0.
- R4: When more than one window hits, the lowest-numbered window wins.
- R5: For a direct-mapped hit, physical bit k (20 ≤ k ≤ 31) comes from the PCI address when mask bit k-20 is set, and from the translated base otherwise. Bits 33:32 always come from the translated base, bits 19:2 come from the PCI address, and bits 1:0 are 0. With mask 0x7FF the result is base bits 33:31 followed by address bits 30:2. With mask 0xFFF it is base bits 33:32 followed by address bits 31:2.
- R6: When the winning window has scatter-gather set, `res_sg` is 1 and `res_phys` is 0. On a miss, `res_sg` and `res_phys` are 0.
- R7: On a dual-address cycle (`pci_dac`=1), only window 3 can hit. It hits only if its dual-address enable is set, `pci_addr_hi` equals its upper-dword register, and the low address matches as in R3.
- R8: When window 0 has chip-select follow set, it hits on a single-address cycle exactly when `mem_cs` is 1, whatever the address. It still keeps priority over the other windows.
- R9: A mask that is not a contiguous run of ones starting at bit 0 makes its window never hit. Any lookup that finds an enabled window with such a mask sets `mask_err`, which stays set until reset.
- R10: Each `req_valid` cycle yields exactly one `res_valid` cycle on the next clock, and `res_valid` never appears without a request. `res_claim` equals `res_hit`. Results are 0 on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Window index (3:2) and register select (1:0) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| req_valid | input | 1 | Lookup strobe |
| pci_addr_lo | input | 32 | PCI address, low dword |
| pci_addr_hi | input | 32 | PCI address, high dword (dual-address cycles) |
| pci_dac | input | 1 | Lookup is a dual-address cycle |
| mem_cs | input | 1 | External memory chip-select decode |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | A window claimed the address |
| res_win | output | 2 | Number of the winning window |
| res_sg | output | 1 | Winning window needs scatter-gather translation |
| res_phys | output | 34 | Direct-mapped physical address |
| res_claim | output | 1 | Target claim for the PCI cycle |
| mask_err | output | 1 | Sticky unsupported-mask flag |

## Verification
The bench builds the decoder with its default of four windows. With that setting, chip-select follow (window 0) and dual-address acceptance (window 3) sit on different windows, and both can contend with the ordinary windows 1 and 2 in priority tests. The 12-bit default mask lets the bench cover the 1MB, 16MB, 128MB, 2GB and 4GB window sizes. It also covers the edges of a window, overlapping windows and a non-contiguous mask, each against a reference model computed with address arithmetic.

// File: rtl/dmawin_pkg.sv
`timescale 1ns/1ps
package dmawin_pkg;
    localparam int ADDR_W = 32;
    localparam int WIN_LO = 20;
    localparam int MASK_W = ADDR_W - WIN_LO;
    localparam int PHYS_W = 34;
    localparam int TB_W   = PHYS_W - WIN_LO;
    localparam int CTRL_W = 4;

    // control bit positions in the base/control register
    localparam int B_EN  = 0;
    localparam int B_SG  = 1;
    localparam int B_DAC = 2;
    localparam int B_CS  = 3;

    typedef enum logic [1:0] {
        SEL_BASE  = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_TBASE = 2'd2,
        SEL_DACHI = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              en;
        logic              sg;
        logic              dac_en;
        logic              cs_en;
        logic [MASK_W-1:0] base;
        logic [MASK_W-1:0] mask;
        logic [TB_W-1:0]   tbase;
    } win_cfg_t;

    typedef struct packed {
        logic              hit;
        logic              bad;
        logic              sg;
        logic [PHYS_W-1:0] phys;
    } win_res_t;

    // a legal mask is a run of ones anchored at bit 0 (including all zero)
    function automatic logic mask_contig(input logic [MASK_W-1:0] m);
        return ((m & (m + MASK_W'(1))) == '0);
    endfunction

    // compare only the positions the mask leaves fixed
    function automatic logic base_match(input logic [ADDR_W-1:0] a,
                                        input logic [MASK_W-1:0] base,
                                        input logic [MASK_W-1:0] m);
        return (((a[ADDR_W-1:WIN_LO] ^ base) & ~m) == '0);
    endfunction

    // direct-mapped translation: mask ones pass address bits, zeros take base bits
    function automatic logic [PHYS_W-1:0] direct_xlate(input logic [MASK_W-1:0] m,
                                                       input logic [TB_W-1:0]   tb,
                                                       input logic [ADDR_W-1:0] a);
        logic [PHYS_W-1:0] p;
        p = '0;
        p[WIN_LO-1:2] = a[WIN_LO-1:2];
        for (int j = 0; j < MASK_W; j++)
            p[WIN_LO+j] = m[j] ? a[WIN_LO+j] : tb[j];
        for (int j = MASK_W; j < TB_W; j++)
            p[WIN_LO+j] = tb[j];
        return p;
    endfunction
endpackage

// File: rtl/dmawin_regs.sv
`timescale 1ns/1ps
module dmawin_regs
    import dmawin_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int IDX_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_wr,
    input  logic [IDX_W+1:0]         cfg_addr,
    input  logic [ADDR_W-1:0]        cfg_wdata,
    output logic [ADDR_W-1:0]        cfg_rdata,
    output win_cfg_t [NUM_WIN-1:0]   cfg_o,
    output logic [ADDR_W-1:0]        dac_hi_o
);
    localparam int DAC_WIN = NUM_WIN - 1;
    localparam int PAD_W   = ADDR_W - MASK_W - CTRL_W;

    logic [IDX_W-1:0]       wsel;
    reg_sel_e               sel;
    win_cfg_t [NUM_WIN-1:0] cfg_q;
    logic [ADDR_W-1:0]      dac_hi_q;
    win_cfg_t               rd;
    logic                   unused_wdata;

    assign wsel = cfg_addr[IDX_W+1:2];
    assign sel  = reg_sel_e'(cfg_addr[1:0]);
    assign unused_wdata = ^{cfg_wdata[WIN_LO-1:TB_W], cfg_wdata[B_CS+1 +: (TB_W-B_CS-1)]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            dac_hi_q <= '0;
        end else if (cfg_wr) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                if (wsel == IDX_W'(i)) begin
                    case (sel)
                        SEL_BASE: begin
                            cfg_q[i].en     <= cfg_wdata[B_EN];
                            cfg_q[i].sg     <= cfg_wdata[B_SG];
                            cfg_q[i].dac_en <= (i == DAC_WIN) ? cfg_wdata[B_DAC] : 1'b0;
                            cfg_q[i].cs_en  <= (i == 0) ? cfg_wdata[B_CS] : 1'b0;
                            cfg_q[i].base   <= cfg_wdata[ADDR_W-1:WIN_LO];
                        end
                        SEL_MASK:  cfg_q[i].mask  <= cfg_wdata[ADDR_W-1:WIN_LO];
                        SEL_TBASE: cfg_q[i].tbase <= cfg_wdata[TB_W-1:0];
                        default: begin
                            if (i == DAC_WIN) dac_hi_q <= cfg_wdata;
                        end
                    endcase
                end
            end
        end
    end

    always_comb begin
        rd        = cfg_q[wsel];
        cfg_rdata = '0;
        case (sel)
            SEL_BASE:  cfg_rdata = {rd.base, {PAD_W{1'b0}}, rd.cs_en, rd.dac_en, rd.sg, rd.en};
            SEL_MASK:  cfg_rdata = {rd.mask, {WIN_LO{1'b0}}};
            SEL_TBASE: cfg_rdata = {{(ADDR_W-TB_W){1'b0}}, rd.tbase};
            default:   cfg_rdata = (wsel == IDX_W'(DAC_WIN)) ? dac_hi_q : '0;
        endcase
    end

    assign cfg_o    = cfg_q;
    assign dac_hi_o = dac_hi_q;
endmodule

// File: rtl/dmawin_match.sv
`timescale 1ns/1ps
module dmawin_match
    import dmawin_pkg::*;
#(
    parameter bit DAC_OK = 1'b0,
    parameter bit CS_OK  = 1'b0
) (
    input  win_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr_lo,
    input  logic [ADDR_W-1:0] addr_hi,
    input  logic [ADDR_W-1:0] dac_hi,
    input  logic              dac,
    input  logic              mem_cs,
    output win_res_t          res
);
    logic legal;
    logic cmp;
    logic take;

    always_comb begin
        legal = mask_contig(cfg.mask);
        cmp   = base_match(addr_lo, cfg.base, cfg.mask);
        if (dac)
            take = DAC_OK && cfg.dac_en && (addr_hi == dac_hi) && cmp;
        else if (CS_OK && cfg.cs_en)
            take = mem_cs;
        else
            take = cmp;
        res.hit  = cfg.en && legal && take;
        res.bad  = cfg.en && !legal;
        res.sg   = cfg.sg;
        res.phys = direct_xlate(cfg.mask, cfg.tbase, addr_lo);
    end
endmodule

// File: rtl/dmawin_select.sv
`timescale 1ns/1ps
module dmawin_select
    import dmawin_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int IDX_W   = 2
) (
    input  win_res_t [NUM_WIN-1:0] res,
    output logic                   any_hit,
    output logic                   any_bad,
    output logic [IDX_W-1:0]       win,
    output logic                   sg,
    output logic [PHYS_W-1:0]      phys
);
    // walk from the top so the lowest hitting index is the last to assign
    always_comb begin
        any_hit = 1'b0;
        any_bad = 1'b0;
        win     = '0;
        sg      = 1'b0;
        phys    = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            any_bad = any_bad | res[i].bad;
            if (res[i].hit) begin
                any_hit = 1'b1;
                win     = IDX_W'(i);
                sg      = res[i].sg;
                phys    = res[i].sg ? '0 : res[i].phys;
            end
        end
    end
endmodule

// File: rtl/dma_window_decoder.sv
`timescale 1ns/1ps
module dma_window_decoder
    import dmawin_pkg::*;
#(
    parameter  int NUM_WIN = 4,
    localparam int IDX_W   = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [IDX_W+1:0]  cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] pci_addr_lo,
    input  logic [ADDR_W-1:0] pci_addr_hi,
    input  logic              pci_dac,
    input  logic              mem_cs,
    output logic              res_valid,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_win,
    output logic              res_sg,
    output logic [PHYS_W-1:0] res_phys,
    output logic              res_claim,
    output logic              mask_err
);
    win_cfg_t [NUM_WIN-1:0] wcfg;
    logic [ADDR_W-1:0]      dac_hi;
    win_res_t [NUM_WIN-1:0] wres;
    logic                   any_hit;
    logic                   any_bad;
    logic [IDX_W-1:0]       sel_win;
    logic                   sel_sg;
    logic [PHYS_W-1:0]      sel_phys;

    dmawin_regs #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg_o     (wcfg),
        .dac_hi_o  (dac_hi)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
        dmawin_match #(
            .DAC_OK (i == NUM_WIN - 1),
            .CS_OK  (i == 0)
        ) u_match (
            .cfg     (wcfg[i]),
            .addr_lo (pci_addr_lo),
            .addr_hi (pci_addr_hi),
            .dac_hi  (dac_hi),
            .dac     (pci_dac),
            .mem_cs  (mem_cs),
            .res     (wres[i])
        );
    end

    dmawin_select #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_select (
        .res     (wres),
        .any_hit (any_hit),
        .any_bad (any_bad),
        .win     (sel_win),
        .sg      (sel_sg),
        .phys    (sel_phys)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_win   <= '0;
            res_sg    <= 1'b0;
            res_phys  <= '0;
            mask_err  <= 1'b0;
        end else begin
            res_valid <= req_valid;
            res_hit   <= req_valid && any_hit;
            res_win   <= (req_valid && any_hit) ? sel_win : '0;
            res_sg    <= req_valid && any_hit && sel_sg;
            res_phys  <= (req_valid && any_hit) ? sel_phys : '0;
            mask_err  <= mask_err || (req_valid && any_bad);
        end
    end

    assign res_claim = res_hit;
endmodule

// File: rtl/dmawin_chk.sv
`timescale 1ns/1ps
module dmawin_chk
    import dmawin_pkg::*;
#(
    parameter  int NUM_WIN = 4,
    localparam int IDX_W   = $clog2(NUM_WIN)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              pci_dac,
    input logic              res_valid,
    input logic              res_hit,
    input logic [IDX_W-1:0]  res_win,
    input logic              res_sg,
    input logic [PHYS_W-1:0] res_phys,
    input logic              mask_err
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!res_valid && !mask_err));

    // R10
    result_has_request_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(req_valid));

    // R10
    hit_within_result_chk: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> res_valid);

    // R6
    sg_only_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
        res_sg |-> res_hit);

    // R6
    phys_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (res_sg || !res_hit) |-> (res_phys == '0));

    // R5
    phys_dword_chk: assert property (@(posedge clk) disable iff (rst)
        res_phys[1:0] == 2'b00);

    // R7
    dac_top_window_chk: assert property (@(posedge clk) disable iff (rst)
        (res_hit && $past(pci_dac)) |-> (res_win == IDX_W'(NUM_WIN - 1)));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(mask_err) |-> mask_err);

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mask_err) |-> $past(req_valid));
endmodule

bind dma_window_decoder dmawin_chk #(.NUM_WIN(NUM_WIN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .pci_dac   (pci_dac),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_win   (res_win),
    .res_sg    (res_sg),
    .res_phys  (res_phys),
    .mask_err  (mask_err)
);

// File: tb/dma_window_decoder_test.sv
`timescale 1ns/1ps
module dma_window_decoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] pci_addr_lo = '0;
    logic [31:0] pci_addr_hi = '0;
    logic        pci_dac = 1'b0;
    logic        mem_cs = 1'b0;
    logic        res_valid, res_hit, res_sg, res_claim, mask_err;
    logic [1:0]  res_win;
    logic [33:0] res_phys;

    always #4 clk = ~clk;

    dma_window_decoder uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .pci_addr_lo(pci_addr_lo), .pci_addr_hi(pci_addr_hi), .pci_dac(pci_dac),
        .mem_cs(mem_cs), .res_valid(res_valid), .res_hit(res_hit), .res_win(res_win),
        .res_sg(res_sg), .res_phys(res_phys), .res_claim(res_claim), .mask_err(mask_err)
    );

    typedef struct packed {
        logic        hit;
        logic [1:0]  win;
        logic        sg;
        logic [33:0] phys;
        logic        err;
    } exp_t;

    exp_t  q[$];
    string tq[$];
    int    total = 0;
    int    bad = 0;
    bit    done = 0;

    // bench-side view of the programmed windows
    logic        sh_en[4], sh_sg[4], sh_dac[4], sh_cs[4];
    logic [11:0] sh_base[4], sh_mask[4];
    logic [13:0] sh_tb[4];
    logic [31:0] sh_dachi;
    logic        model_err;

    task automatic shadow_clear();
        for (int w = 0; w < 4; w++) begin
            sh_en[w] = 0; sh_sg[w] = 0; sh_dac[w] = 0; sh_cs[w] = 0;
            sh_base[w] = '0; sh_mask[w] = '0; sh_tb[w] = '0;
        end
        sh_dachi  = '0;
        model_err = 0;
    endtask

    task automatic check(input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic wr(input int w, input int s, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1; cfg_addr = 4'(w * 4 + s); cfg_wdata = d;
        case (s)
            0: begin
                sh_en[w] = d[0]; sh_sg[w] = d[1];
                sh_dac[w] = (w == 3) && d[2];
                sh_cs[w]  = (w == 0) && d[3];
                sh_base[w] = d[31:20];
            end
            1: sh_mask[w] = d[31:20];
            2: sh_tb[w] = d[13:0];
            default: if (w == 3) sh_dachi = d;
        endcase
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic rd(input int w, input int s, input logic [31:0] exp, input string rq);
        @(negedge clk);
        cfg_addr = 4'(w * 4 + s);
        #1;
        check(rq, "register read", cfg_rdata, exp);
    endtask

    // reference built from the requirements with plain address arithmetic
    task automatic look(input logic [31:0] lo, input logic [31:0] hi,
                        input logic dac, input logic cs, input string rq);
        exp_t e;
        logic found;
        e = '0; found = 0;
        for (int w = 0; w < 4; w++) begin
            int kk;
            logic [63:0] sz, lo64, b64, t64;
            logic match, h;
            kk = -1;
            for (int k = 0; k <= 12; k++)
                if (sh_mask[w] == 12'((1 << k) - 1)) kk = k;
            if (sh_en[w] && kk < 0) model_err = 1;
            if (sh_en[w] && kk >= 0) begin
                sz   = 64'd1 << (20 + kk);
                lo64 = {32'd0, lo};
                b64  = {32'd0, sh_base[w], 20'd0};
                t64  = {30'd0, sh_tb[w], 20'd0};
                match = ((lo64 ^ b64) & ~(sz - 64'd1)) == 64'd0;
                if (dac) h = (w == 3) && sh_dac[w] && (hi == sh_dachi) && match;
                else if (w == 0 && sh_cs[0]) h = cs;
                else h = match;
                if (h && !found) begin
                    found = 1;
                    e.hit = 1; e.win = 2'(w); e.sg = sh_sg[w];
                    e.phys = sh_sg[w] ? 34'd0 :
                             34'(((t64 & ~(sz - 64'd1)) | (lo64 & (sz - 64'd1))) & ~64'd3);
                end
            end
        end
        e.err = model_err;
        @(negedge clk);
        req_valid = 1; pci_addr_lo = lo; pci_addr_hi = hi; pci_dac = dac; mem_cs = cs;
        q.push_back(e);
        tq.push_back(rq);
        @(negedge clk);
        req_valid = 0; pci_dac = 0; mem_cs = 0;
    endtask

    // monitor: compare each result against the queued expectation
    exp_t  mon_e;
    string mon_t;
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (q.size() == 0) begin
                check("R10", "result without request", 64'd1, 64'd0);
            end else begin
                mon_e = q.pop_front();
                mon_t = tq.pop_front();
                check(mon_t, "hit", res_hit, mon_e.hit);
                check(mon_t, "claim (R10)", res_claim, mon_e.hit);
                if (mon_e.hit) check(mon_t, "window", res_win, mon_e.win);
                check(mon_t, "sg", res_sg, mon_e.sg);
                check(mon_t, "phys", res_phys, mon_e.phys);
                check(mon_t, "mask_err", mask_err, mon_e.err);
            end
        end
    end

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        finish_up();
    end

    initial begin
        shadow_clear();
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1", "res_valid in reset", res_valid, 0);
        check("R1", "mask_err in reset", mask_err, 0);
        check("R1", "claim in reset", res_claim, 0);
        rst = 0;
        for (int w = 0; w < 4; w++) rd(w, 0, 32'h0, "R1");
        rd(3, 3, 32'h0, "R1");

        // R2 field layout and per-window bits
        wr(1, 0, 32'h0400_000F);  rd(1, 0, 32'h0400_0003, "R2");
        wr(0, 0, 32'h0010_0009);  rd(0, 0, 32'h0010_0009, "R2");
        wr(3, 0, 32'h8000_000F);  rd(3, 0, 32'h8000_0007, "R2");
        wr(1, 3, 32'hDEAD_BEEF);  rd(1, 3, 32'h0, "R2");
        wr(3, 3, 32'h0000_0001);  rd(3, 3, 32'h0000_0001, "R2");
        wr(2, 1, 32'h07F0_0000);  rd(2, 1, 32'h07F0_0000, "R2");
        wr(2, 2, 32'hFFFF_3ABC);  rd(2, 2, 32'h0000_3ABC, "R2");

        // base configuration
        wr(0, 0, 32'h0010_0001); wr(0, 1, 32'h0000_0000); wr(0, 2, 32'h0000_0050);
        wr(1, 0, 32'h0400_0001); wr(1, 1, 32'h00F0_0000); wr(1, 2, 32'h0000_03A0);
        wr(2, 0, 32'h0800_0003); wr(2, 1, 32'h07F0_0000); wr(2, 2, 32'h0000_0000);
        wr(3, 0, 32'h8000_0001); wr(3, 1, 32'h7FF0_0000); wr(3, 2, 32'h0000_2000);

        // R3 / R5 / R6 window compares and translation
        look(32'h0012_3454, 0, 0, 0, "R5");
        look(32'h0030_0000, 0, 0, 0, "R3");
        look(32'h04AB_CDE8, 0, 0, 0, "R5");
        look(32'h04FF_FFFC, 0, 0, 0, "R3");
        look(32'h0500_0000, 0, 0, 0, "R3");
        look(32'h03FF_FFFC, 0, 0, 0, "R3");
        look(32'h0A00_0010, 0, 0, 0, "R6");
        look(32'hC000_1237, 0, 0, 0, "R5");
        repeat (3) @(negedge clk);   // idle gap: R10 no stray results

        // R4 priority on overlapping windows
        wr(1, 0, 32'h0000_0001);
        look(32'h0010_0010, 0, 0, 0, "R4");
        look(32'h0020_0000, 0, 0, 0, "R4");
        wr(0, 0, 32'h0010_0000);
        look(32'h0010_0010, 0, 0, 0, "R4");
        wr(0, 0, 32'h0010_0001);
        wr(1, 0, 32'h0400_0001);

        // R7 dual-address cycles
        look(32'h0012_3454, 32'h1, 1, 0, "R7");
        look(32'h8000_0040, 32'h1, 1, 0, "R7");
        wr(3, 0, 32'h8000_0005);
        look(32'h8000_0040, 32'h1, 1, 0, "R7");
        look(32'h0012_3454, 32'h1, 1, 0, "R7");
        look(32'h8000_0040, 32'h2, 1, 0, "R7");
        look(32'h8000_0040, 32'h0, 0, 0, "R7");

        // R8 chip-select follow on window 0
        wr(0, 0, 32'h0010_0009);
        look(32'h0012_3454, 0, 0, 0, "R8");
        look(32'h0A00_0010, 0, 0, 1, "R8");
        look(32'h0070_0000, 0, 0, 1, "R8");
        look(32'h8000_0040, 32'h1, 1, 1, "R8");
        wr(0, 0, 32'h0010_0001);

        // R5 4GB window
        wr(3, 1, 32'hFFF0_0000); wr(3, 2, 32'h0000_3000);
        look(32'h1234_5678, 0, 0, 0, "R5");

        // R9 unsupported mask
        wr(2, 1, 32'h0050_0000);
        look(32'h0800_0000, 0, 0, 0, "R9");
        wr(2, 1, 32'h07F0_0000);
        look(32'h0800_0000, 0, 0, 0, "R9");
        look(32'h0030_0000, 0, 0, 0, "R9");

        repeat (3) @(negedge clk);
        check("R10", "pending results", q.size(), 0);

        // R1 reset again clears sticky error and registers
        rst = 1;
        repeat (2) @(negedge clk);
        check("R1", "mask_err after reset", mask_err, 0);
        check("R1", "res_valid after reset", res_valid, 0);
        rst = 0;
        shadow_clear();
        rd(3, 0, 32'h0, "R1");
        rd(0, 2, 32'h0, "R1");
        look(32'h0010_0000, 0, 0, 0, "R1");
        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule